// File: doc/BRIEF.md
# Iterative Integer Multiply Unit

This execution unit multiplies two 32-bit register values and supports three operations. The single-word multiply returns only the low half of the product. The signed double-word multiply treats both operands as two's-complement values and produces a 64-bit result. The unsigned double-word multiply treats both as unsigned and also produces a 64-bit result.

The core captures both operands on a start strobe and computes the product by radix-2 shift-and-add, one multiplier bit per cycle. It then presents the result words for one cycle, marked by a done strobe. For double-word operations, `hi_o` goes to the named destination register and `lo_o` goes to the register after it. The unit also drives the zero and negative condition flags, together with a per-flag update mask. The mask marks overflow and carry as left unchanged.

The signed case runs on operand magnitudes. The 64-bit product is negated when the operand signs differ, so every operation takes the same number of cycles.

Top module: `mul_unit`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `done_o`, `pair_wr_o`, `flag_z_o`, `flag_n_o`, `hi_o`, `lo_o` and `flag_upd_o` are all zero.
- R2: A start is accepted only on a rising edge where `start_i` is high, the unit is idle and the op code is valid. `busy_o` is high from the next cycle until the done cycle. A start while busy has no effect on the result or the timing.
- R3: `done_o` rises exactly DATA_W+1 cycles after the accepting edge and stays high for one cycle. The result and flag outputs then hold their values until the next done.
- R4: Op code 2'b00 (single-word) gives `lo_o` equal to the low DATA_W bits of the product, with `hi_o` zero and `pair_wr_o` low. The result is independent of operand signedness.
- R5: Op code 2'b01 (signed double-word) gives {`hi_o`,`lo_o`} equal to the two's-complement product of the operands, with `pair_wr_o` high. This includes the most negative value times -1 and times itself.
- R6: Op code 2'b10 (unsigned double-word) gives {`hi_o`,`lo_o`} equal to the unsigned product, with `pair_wr_o` high.
- R7: `flag_z_o` is set when the written result is zero: the low word alone for op 2'b00, and all 2*DATA_W bits for the double-word ops.
- R8: `flag_n_o` equals bit DATA_W-1 of `lo_o` for op 2'b00, and bit DATA_W-1 of `hi_o` for the double-word ops.
- R9: `flag_upd_o` (bit 3 N, bit 2 Z, bit 1 V, bit 0 C) is 4'b1100 in the done cycle and 4'b0000 otherwise.
- R10: Op code 2'b11 is reserved. A start with it is ignored: `busy_o` stays low and no done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| op_i | input | 2 | Operation: 00 single-word, 01 signed pair, 10 unsigned pair |
| rd_val_i | input | DATA_W | Destination register value (first operand) |
| rs_val_i | input | DATA_W | Source register value (second operand) |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle result strobe |
| hi_o | output | DATA_W | High product word (destination register); zero for single-word |
| lo_o | output | DATA_W | Low product word (next register, or destination for single-word) |
| pair_wr_o | output | 1 | Two registers are written |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_upd_o | output | 4 | Flag update mask {N,Z,V,C} |

## Verification
The assertions assume that reset is applied from time zero and that `start_i` and `op_i` are known values at every sampling edge. Operands are sampled only on the accepting edge, so the assertions do not constrain them afterwards.

The bench changes inputs only at falling edges and raises `start_i` for exactly one cycle per request. It leaves a deliberate mid-operation start as the only stimulus that reaches the unit while it is busy. Operands are a cross product of corner values (zero, one, all ones, the most negative and most positive values and their neighbours), followed by pseudo-random pairs, for all three op codes.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    OP_MUL_LO = 2'b00,
    OP_MUL_S  = 2'b01,
    OP_MUL_U  = 2'b10,
    OP_RSVD   = 2'b11
  } mul_op_e;

  // flag mask order {N,Z,V,C}; V and C left untouched
  localparam logic [3:0] FLAG_UPD_NZ = 4'b1100;
endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] a_mag_o,
  output logic [DATA_W-1:0] b_mag_o,
  output logic              neg_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic a_neg, b_neg;

  assign a_neg   = signed_i & a_i[DATA_W-1];
  assign b_neg   = signed_i & b_i[DATA_W-1];
  // most negative value maps to itself, which is correct as unsigned magnitude
  assign a_mag_o = a_neg ? (~a_i + ONE) : a_i;
  assign b_mag_o = b_neg ? (~b_i + ONE) : b_i;
  assign neg_o   = a_neg ^ b_neg;
endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [DATA_W-1:0]   mcand_i,
  input  logic [DATA_W-1:0]   mplr_i,
  output logic [2*DATA_W-1:0] acc_o,
  output logic                last_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned CNT_W  = $clog2(DATA_W);

  logic [PROD_W-1:0] mcand_q, acc_q;
  logic [DATA_W-1:0] mplr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      mplr_q  <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      mcand_q <= {{DATA_W{1'b0}}, mcand_i};
      mplr_q  <= mplr_i;
      acc_q   <= '0;
      cnt_q   <= '0;
    end else if (step_i) begin
      acc_q   <= acc_q + (mplr_q[0] ? mcand_q : '0);
      mcand_q <= mcand_q << 1;
      mplr_q  <= mplr_q >> 1;
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign acc_o  = acc_q;
  assign last_o = (cnt_q == CNT_W'(DATA_W - 1));

  // R3: iteration counter never wraps mid-operation
  a_r3_cnt_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !last_o |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/mul_result_fmt.sv
module mul_result_fmt #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [2*DATA_W-1:0] acc_i,
  input  logic                negate_i,
  input  logic                pair_i,
  output logic [DATA_W-1:0]   hi_o,
  output logic [DATA_W-1:0]   lo_o,
  output logic                z_o,
  output logic                n_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam logic [PROD_W-1:0] ONE = PROD_W'(1);

  logic [PROD_W-1:0] prod;

  assign prod = negate_i ? (~acc_i + ONE) : acc_i;
  assign hi_o = pair_i ? prod[PROD_W-1:DATA_W] : '0;
  assign lo_o = prod[DATA_W-1:0];
  assign z_o  = pair_i ? (prod == '0) : (prod[DATA_W-1:0] == '0);
  assign n_o  = pair_i ? prod[PROD_W-1] : prod[DATA_W-1];
endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] rd_val_i,
  input  logic [DATA_W-1:0] rs_val_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              pair_wr_o,
  output logic              flag_z_o,
  output logic              flag_n_o,
  output logic [3:0]        flag_upd_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned LAT    = DATA_W + 1;
  localparam int unsigned LAT_W  = $clog2(LAT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  st_e               st_q, st_d;
  mul_op_e           op_in;
  logic              accept, last;
  logic              pair_q, neg_q;
  logic [DATA_W-1:0] a_mag, b_mag;
  logic              neg_in;
  logic [PROD_W-1:0] acc;
  logic [DATA_W-1:0] f_hi, f_lo;
  logic              f_z, f_n;

  assign op_in  = mul_op_e'(op_i);
  assign accept = (st_q == ST_IDLE) && start_i && (op_in != OP_RSVD);

  mul_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .a_i      (rd_val_i),
    .b_i      (rs_val_i),
    .signed_i (op_in == OP_MUL_S),
    .a_mag_o  (a_mag),
    .b_mag_o  (b_mag),
    .neg_o    (neg_in)
  );

  mul_shift_add #(.DATA_W(DATA_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .step_i  (st_q == ST_RUN),
    .mcand_i (a_mag),
    .mplr_i  (b_mag),
    .acc_o   (acc),
    .last_o  (last)
  );

  mul_result_fmt #(.DATA_W(DATA_W)) u_fmt (
    .acc_i    (acc),
    .negate_i (neg_q),
    .pair_i   (pair_q),
    .hi_o     (f_hi),
    .lo_o     (f_lo),
    .z_o      (f_z),
    .n_o      (f_n)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_RUN;
      ST_RUN:  if (last)   st_d = ST_FIN;
      ST_FIN:              st_d = ST_IDLE;
      default:             st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pair_q <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        pair_q <= (op_in != OP_MUL_LO);
        neg_q  <= neg_in;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      hi_o      <= '0;
      lo_o      <= '0;
      pair_wr_o <= 1'b0;
      flag_z_o  <= 1'b0;
      flag_n_o  <= 1'b0;
    end else begin
      done_o <= (st_q == ST_FIN);
      if (st_q == ST_FIN) begin
        hi_o      <= f_hi;
        lo_o      <= f_lo;
        pair_wr_o <= pair_q;
        flag_z_o  <= f_z;
        flag_n_o  <= f_n;
      end
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign flag_upd_o = done_o ? FLAG_UPD_NZ : 4'b0000;

  // cycles since the accepting edge, for latency checking only
  logic [LAT_W-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   since_q <= '0;
    else if (accept)                               since_q <= '0;
    else if (busy_o && since_q != LAT_W'(LAT))     since_q <= since_q + LAT_W'(1);
  end

  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> since_q == LAT_W'(LAT));
  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(hi_o) && $stable(lo_o) && $stable(flag_z_o) && $stable(flag_n_o));
  a_r2_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(pair_q) && $stable(neg_q));
  a_r4_sw_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !pair_wr_o |-> hi_o == '0);
  a_r7_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> flag_z_o == ({hi_o, lo_o} == '0));
  a_r8_neg_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> flag_n_o == (pair_wr_o ? hi_o[DATA_W-1] : lo_o[DATA_W-1]));
  a_r9_mask_only_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_upd_o != 4'b0000 |-> done_o);
  a_r10_rsvd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && op_i == 2'b11 |=> !busy_o);
endmodule

// File: tb/mul_unit_tb_top.sv
module mul_unit_tb_top;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [DW-1:0] a = '0, b = '0;
  logic          busy, done, pair_wr, fz, fn;
  logic [DW-1:0] hi, lo;
  logic [3:0]    fupd;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mul_unit #(.DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .rd_val_i(a), .rs_val_i(b), .busy_o(busy), .done_o(done),
    .hi_o(hi), .lo_o(lo), .pair_wr_o(pair_wr), .flag_z_o(fz),
    .flag_n_o(fn), .flag_upd_o(fupd)
  );

  task automatic chk(input string req, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [DW-1:0] x, input logic [DW-1:0] y,
                        input bit poke);
    logic [2*DW-1:0] exp;
    logic [DW-1:0]   e_hi, e_lo;
    logic            e_z, e_n, e_pair;
    logic signed [2*DW-1:0] sx, sy;
    int lat;
    sx = {{DW{x[DW-1]}}, x};
    sy = {{DW{y[DW-1]}}, y};
    case (o)
      2'b01:   exp = sx * sy;
      default: exp = {{DW{1'b0}}, x} * {{DW{1'b0}}, y};
    endcase
    e_pair = (o != 2'b00);
    e_hi   = e_pair ? exp[2*DW-1:DW] : '0;
    e_lo   = exp[DW-1:0];
    e_z    = e_pair ? (exp == '0) : (e_lo == '0);
    e_n    = e_pair ? e_hi[DW-1] : e_lo[DW-1];

    @(negedge clk);
    op = o; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = ~x; b = ~y; // operands must have been captured
    chk("R2 busy after accept", {63'b0, busy}, 64'd1);
    lat = 1;
    while (!done && lat < 100) begin
      if (poke && lat == 5) begin
        op = 2'b01; a = 32'h1234_5678; b = 32'h8765_4321; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk("R3 done latency", 64'(lat), 64'(DW + 2));
    chk(o == 2'b00 ? "R4 single-word hi" : (o == 2'b01 ? "R5 signed hi" : "R6 unsigned hi"),
        {32'b0, hi}, {32'b0, e_hi});
    chk(o == 2'b00 ? "R4 single-word lo" : (o == 2'b01 ? "R5 signed lo" : "R6 unsigned lo"),
        {32'b0, lo}, {32'b0, e_lo});
    chk("R4 pair write", {63'b0, pair_wr}, {63'b0, e_pair});
    chk("R7 zero flag", {63'b0, fz}, {63'b0, e_z});
    chk("R8 negative flag", {63'b0, fn}, {63'b0, e_n});
    chk("R9 flag mask in done", {60'b0, fupd}, 64'hC);
    chk("R2 busy low in done", {63'b0, busy}, 64'd0);
    @(negedge clk);
    chk("R3 done single cycle", {63'b0, done}, 64'd0);
    chk("R9 flag mask idle", {60'b0, fupd}, 64'd0);
    chk("R3 result held", {hi, lo}, {e_hi, e_lo});
  endtask

  logic [DW-1:0] corner [10];

  initial begin
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'h0000_0002;
    corner[3] = 32'hFFFF_FFFF; corner[4] = 32'hFFFF_FFFE; corner[5] = 32'h8000_0000;
    corner[6] = 32'h7FFF_FFFF; corner[7] = 32'h8000_0001; corner[8] = 32'h0001_0000;
    corner[9] = 32'h0000_FFFF;

    #3;
    // R1 reset state
    chk("R1 busy", {63'b0, busy}, 64'd0);
    chk("R1 done", {63'b0, done}, 64'd0);
    chk("R1 result", {hi, lo}, 64'd0);
    chk("R1 flags", {58'b0, pair_wr, fz, fn, fupd[2:0]}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {hi, lo}, 64'd0);
    chk("R1 mask after release", {60'b0, fupd}, 64'd0);

    // R10 reserved op ignored
    op = 2'b11; a = 32'd3; b = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < DW + 4; i++) begin
      if (busy || done) begin
        chk("R10 reserved op busy/done", {62'b0, busy, done}, 64'd0);
        break;
      end
      @(negedge clk);
    end
    chk("R10 reserved op no result", {hi, lo}, 64'd0);

    // R5 most negative cases explicitly
    run_op(2'b01, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_op(2'b01, 32'h8000_0000, 32'h8000_0000, 0);
    // R2 start while busy ignored
    run_op(2'b10, 32'hDEAD_BEEF, 32'h0000_0003, 1);
    run_op(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 1);

    // corner cross product, all ops (R4 R5 R6 R7 R8)
    for (int o = 0; o < 3; o++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_op(2'(o), corner[i], corner[j], 0);

    // pseudo-random pairs
    for (int k = 0; k < 150; k++)
      for (int o = 0; o < 3; o++)
        run_op(2'(o), $urandom, $urandom, 0);

    finish_run();
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule